// File: doc/BRIEF.md
# Arbitrated Multiplexed-Bus Master

This block moves single words between on-chip logic and a shared expansion bus. The bus carries address and data on one set of lines and uses separate address and data strobes. Before each transfer the master asks an outside arbiter for the bus with an active-low request line. Once the arbiter grants the bus, the master drives its command lines, then the address, and then asserts an acknowledge to claim ownership. It next runs the strobe sequence and either drives write data or captures read data. When the transfer is over it drops its request and parks: the command lines are driven to their idle levels and the shared lines are floated.

The on-chip side offers one request at a time through a valid/ready handshake. That request carries the address, a write flag, the write data and active-high byte enables. A one-cycle done pulse answers it, carrying read data and an abort flag. Three 4-bit stretch values are taken when a request is accepted. They lengthen the address phase, the data strobe and the minimum idle time between requests. If the arbiter takes the grant away at any point, the master floats all shared lines on the next clock and reports the transfer as aborted. It never retries that transfer. Each three-state line appears as a value output plus an output enable.

Top module: `xbus_master`

## Requirements
- R1: When reset is released, the request line is high and both output enables are low. Whenever the request and grant lines are both sampled high, both enables are low on the next clock.
- R2: `req_ready` is high only while the master is idle or parked and the request gap has run out. A request accepted on a clock edge drives `bus_req_n` low after that same edge. At most one transfer is in progress at any time.
- R3: Let edge k be the edge on which the master, with its request pending, samples the grant low. Valid command values (strobes high, `bus_rw_n` equal to the inverse of the write flag, `bus_be_n` equal to the inverse of the enables) are driven after edge k. The address is driven after edge k+1. `bus_ack_n` goes low after edge k+2.
- R4: With address stretch A, `bus_as_n` goes low after edge k+3+A. The address stays on the lines for one further clock.
- R5: On a write, the write data replaces the address after edge k+4+A and `bus_rw_n` is low. On a read, `bus_ad_oe` falls after edge k+4+A and `bus_rw_n` is high. In both cases `bus_ds_n` goes low after edge k+5+A.
- R6: With data stretch D, `bus_ds_n` stays low for 1+D clocks. `bus_ack_n` rises on the same edge that raises `bus_ds_n`. A read captures `bus_ad_i` on that edge.
- R7: One clock after the data strobe rises, several things happen together. `bus_req_n` goes high. Strobes, direction and byte enables return to their idle levels. The address/data lines are floated. `rsp_done` pulses for one clock with `rsp_abort` low, and `rsp_rdata` carries the captured word.
- R8: While parked with the grant low, the command enables stay high. If the grant is sampled high while parked, `bus_cmd_oe` is low on the next clock. A new request accepted while parked runs without the command lines ever being released.
- R9: With gap value G, `bus_req_n` stays high for at least 1+G clocks between transfers.
- R10: If the grant is sampled high at any edge from k+1 through the edge that raises the data strobe, the next clock does all of the following. Both enables go low. The request goes high. `rsp_done` pulses with `rsp_abort` high. The transfer is not requested again.
- R11: All three stretch values are taken at the accepting edge. A change to them later has no effect on the transfer in progress.
- R12: A grant that arrives with no request pending is ignored, and no shared line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | BUS_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | BUS_W | Write data |
| req_be | input | BUS_W/8 | Byte enables, active high |
| cfg_astretch | input | CNT_W | Extra address-phase clocks |
| cfg_dstretch | input | CNT_W | Extra data-strobe clocks |
| cfg_gap | input | CNT_W | Extra idle clocks between requests |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_abort | output | 1 | Transfer was cut short by grant loss |
| rsp_rdata | output | BUS_W | Captured read data |
| bus_req_n | output | 1 | Bus request to arbiter, active low |
| bus_grant_n | input | 1 | Bus grant from arbiter, active low |
| bus_ack_n | output | 1 | Grant acknowledge, active low (command enable) |
| bus_as_n | output | 1 | Address strobe, active low (command enable) |
| bus_ds_n | output | 1 | Data strobe, active low (command enable) |
| bus_rw_n | output | 1 | High = read, low = write (command enable) |
| bus_be_n | output | BUS_W/8 | Byte enables, active low (command enable) |
| bus_cmd_oe | output | 1 | Output enable for all command lines |
| bus_ad_o | output | BUS_W | Address/data value driven |
| bus_ad_oe | output | 1 | Output enable for address/data lines |
| bus_ad_i | input | BUS_W | Address/data value sampled |

## Verification
A sequencer that is in the wrong phase shows up on the strobe lines within one clock. The strobe edge lands one or more clocks away from k+3+A or k+5+A, and a reference that counts from the grant edge flags it on that clock. A phase counter that loads a live stretch value instead of the latched one stretches the strobe, and the change can be seen once the first strobe edge is due. A state that misses grant loss leaves an output enable high on the clock after the grant rises. A gap counter that misses its load moves `req_ready` and `bus_req_n` by at least one clock on the next request.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [3:0] {
    XS_IDLE,
    XS_PARK,
    XS_REQ,
    XS_CMD,
    XS_ADR,
    XS_AST,
    XS_AHD,
    XS_DSU,
    XS_DAT,
    XS_TAIL
  } xbus_state_e;

  function automatic logic in_transfer(input xbus_state_e s);
    return (s == XS_CMD) || (s == XS_ADR) || (s == XS_AST) ||
           (s == XS_AHD) || (s == XS_DSU) || (s == XS_DAT);
  endfunction

endpackage

// File: rtl/xbus_down_cnt.sv
module xbus_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/xbus_req_hold.sv
module xbus_req_hold #(
  parameter int BUS_W = 32,
  parameter int CNT_W = 4,
  localparam int BE_W = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [BUS_W-1:0] in_addr,
  input  logic             in_write,
  input  logic [BUS_W-1:0] in_wdata,
  input  logic [BE_W-1:0]  in_be,
  input  logic [CNT_W-1:0] in_ast,
  input  logic [CNT_W-1:0] in_dst,
  input  logic [CNT_W-1:0] in_gap,
  output logic [BUS_W-1:0] h_addr,
  output logic             h_write,
  output logic [BUS_W-1:0] h_wdata,
  output logic [BE_W-1:0]  h_be_n,
  output logic [CNT_W-1:0] h_ast,
  output logic [CNT_W-1:0] h_dst,
  output logic [CNT_W-1:0] h_gap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      h_addr  <= '0;
      h_write <= 1'b0;
      h_wdata <= '0;
      h_ast   <= '0;
      h_dst   <= '0;
      h_gap   <= '0;
    end else if (take) begin
      h_addr  <= in_addr;
      h_write <= in_write;
      h_wdata <= in_wdata;
      h_ast   <= in_ast;
      h_dst   <= in_dst;
      h_gap   <= in_gap;
    end
  end

  // Per-lane inversion to bus polarity, one register per lane.
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        h_be_n[i] <= 1'b1;
      end else if (take) begin
        h_be_n[i] <= ~in_be[i];
      end
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int BUS_W = 32,
  parameter int CNT_W = 4,
  localparam int BE_W = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             grant_n,
  input  logic [BUS_W-1:0] ad_in,
  input  logic [BUS_W-1:0] h_addr,
  input  logic             h_write,
  input  logic [BUS_W-1:0] h_wdata,
  input  logic [BE_W-1:0]  h_be_n,
  input  logic [CNT_W-1:0] h_ast,
  input  logic [CNT_W-1:0] h_dst,
  input  logic             ph_zero,
  output logic             ph_load,
  output logic [CNT_W-1:0] ph_val,
  output logic             gap_load,
  output logic             can_take,
  output logic             req_n,
  output logic             ack_n,
  output logic             as_n,
  output logic             ds_n,
  output logic             rw_n,
  output logic [BE_W-1:0]  be_n,
  output logic             cmd_oe,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             done,
  output logic             aborted,
  output logic [BUS_W-1:0] rdata
);
  import xbus_pkg::*;

  xbus_state_e st_q;
  logic [BUS_W-1:0] cap_q;
  logic lost;

  assign lost     = grant_n && in_transfer(st_q);
  assign can_take = (st_q == XS_IDLE) || (st_q == XS_PARK);
  assign ph_load  = (st_q == XS_ADR) || (st_q == XS_DSU);
  assign ph_val   = (st_q == XS_ADR) ? h_ast : h_dst;
  assign gap_load = (st_q == XS_TAIL) || lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= XS_IDLE;
      req_n   <= 1'b1;
      ack_n   <= 1'b1;
      as_n    <= 1'b1;
      ds_n    <= 1'b1;
      rw_n    <= 1'b1;
      be_n    <= '1;
      cmd_oe  <= 1'b0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      done    <= 1'b0;
      aborted <= 1'b0;
      rdata   <= '0;
      cap_q   <= '0;
    end else begin
      done <= 1'b0;
      if (lost) begin
        st_q    <= XS_IDLE;
        req_n   <= 1'b1;
        ack_n   <= 1'b1;
        as_n    <= 1'b1;
        ds_n    <= 1'b1;
        rw_n    <= 1'b1;
        be_n    <= '1;
        cmd_oe  <= 1'b0;
        ad_oe   <= 1'b0;
        done    <= 1'b1;
        aborted <= 1'b1;
      end else begin
        unique case (st_q)
          XS_IDLE, XS_PARK: begin
            if (st_q == XS_PARK && grant_n) cmd_oe <= 1'b0;
            if (accept) begin
              req_n <= 1'b0;
              st_q  <= XS_REQ;
            end else if (st_q == XS_PARK && grant_n) begin
              st_q <= XS_IDLE;
            end
          end
          XS_REQ: begin
            if (grant_n) begin
              cmd_oe <= 1'b0;
            end else begin
              cmd_oe <= 1'b1;
              as_n   <= 1'b1;
              ds_n   <= 1'b1;
              rw_n   <= ~h_write;
              be_n   <= h_be_n;
              st_q   <= XS_CMD;
            end
          end
          XS_CMD: begin
            ad_oe  <= 1'b1;
            ad_out <= h_addr;
            st_q   <= XS_ADR;
          end
          XS_ADR: begin
            ack_n <= 1'b0;
            st_q  <= XS_AST;
          end
          XS_AST: begin
            if (ph_zero) begin
              as_n <= 1'b0;
              st_q <= XS_AHD;
            end
          end
          XS_AHD: begin
            if (h_write) ad_out <= h_wdata;
            else         ad_oe  <= 1'b0;
            st_q <= XS_DSU;
          end
          XS_DSU: begin
            ds_n <= 1'b0;
            st_q <= XS_DAT;
          end
          XS_DAT: begin
            if (ph_zero) begin
              ds_n  <= 1'b1;
              ack_n <= 1'b1;
              cap_q <= ad_in;
              st_q  <= XS_TAIL;
            end
          end
          XS_TAIL: begin
            req_n   <= 1'b1;
            as_n    <= 1'b1;
            rw_n    <= 1'b1;
            be_n    <= '1;
            ad_oe   <= 1'b0;
            cmd_oe  <= ~grant_n;
            done    <= 1'b1;
            aborted <= 1'b0;
            rdata   <= cap_q;
            st_q    <= grant_n ? XS_IDLE : XS_PARK;
          end
          default: st_q <= XS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xbus_master.sv
module xbus_master #(
  parameter int BUS_W = 32,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BUS_W-1:0]   req_addr,
  input  logic               req_write,
  input  logic [BUS_W-1:0]   req_wdata,
  input  logic [BUS_W/8-1:0] req_be,
  input  logic [CNT_W-1:0]   cfg_astretch,
  input  logic [CNT_W-1:0]   cfg_dstretch,
  input  logic [CNT_W-1:0]   cfg_gap,
  output logic               rsp_done,
  output logic               rsp_abort,
  output logic [BUS_W-1:0]   rsp_rdata,
  output logic               bus_req_n,
  input  logic               bus_grant_n,
  output logic               bus_ack_n,
  output logic               bus_as_n,
  output logic               bus_ds_n,
  output logic               bus_rw_n,
  output logic [BUS_W/8-1:0] bus_be_n,
  output logic               bus_cmd_oe,
  output logic [BUS_W-1:0]   bus_ad_o,
  output logic               bus_ad_oe,
  input  logic [BUS_W-1:0]   bus_ad_i
);
  localparam int BE_W = BUS_W / 8;

  logic             can_take, gap_zero, accept;
  logic             ph_load, ph_zero, gap_load;
  logic [CNT_W-1:0] ph_val;
  logic [BUS_W-1:0] h_addr, h_wdata;
  logic             h_write;
  logic [BE_W-1:0]  h_be_n;
  logic [CNT_W-1:0] h_ast, h_dst, h_gap;

  assign req_ready = can_take && gap_zero;
  assign accept    = req_valid && req_ready;

  xbus_req_hold #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst(rst), .take(accept),
    .in_addr(req_addr), .in_write(req_write), .in_wdata(req_wdata),
    .in_be(req_be), .in_ast(cfg_astretch), .in_dst(cfg_dstretch),
    .in_gap(cfg_gap),
    .h_addr(h_addr), .h_write(h_write), .h_wdata(h_wdata),
    .h_be_n(h_be_n), .h_ast(h_ast), .h_dst(h_dst), .h_gap(h_gap)
  );

  xbus_down_cnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  xbus_down_cnt #(.W(CNT_W)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(h_gap), .zero(gap_zero)
  );

  xbus_seq #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .grant_n(bus_grant_n),
    .ad_in(bus_ad_i), .h_addr(h_addr), .h_write(h_write),
    .h_wdata(h_wdata), .h_be_n(h_be_n), .h_ast(h_ast), .h_dst(h_dst),
    .ph_zero(ph_zero), .ph_load(ph_load), .ph_val(ph_val),
    .gap_load(gap_load), .can_take(can_take),
    .req_n(bus_req_n), .ack_n(bus_ack_n), .as_n(bus_as_n),
    .ds_n(bus_ds_n), .rw_n(bus_rw_n), .be_n(bus_be_n),
    .cmd_oe(bus_cmd_oe), .ad_out(bus_ad_o), .ad_oe(bus_ad_oe),
    .done(rsp_done), .aborted(rsp_abort), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_done,
  input logic bus_req_n,
  input logic bus_grant_n,
  input logic bus_ack_n,
  input logic bus_as_n,
  input logic bus_ds_n,
  input logic bus_cmd_oe,
  input logic bus_ad_oe
);
  AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (bus_req_n && bus_grant_n) |=> (!bus_cmd_oe && !bus_ad_oe)); // R1

  AST_READY_NOT_REQ: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> bus_req_n); // R2

  AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_n) |-> (!$past(bus_grant_n) && !$past(bus_grant_n, 2))); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_oe && $fell(bus_as_n)) |-> bus_ad_oe); // R4

  AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_oe && !bus_ds_n) |-> (!bus_as_n && !bus_ack_n)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R7

  AST_GRANT_LOSS_FLOAT: assert property (@(posedge clk) disable iff (rst)
    bus_grant_n |=> (!bus_cmd_oe && !bus_ad_oe)); // R10
endmodule

bind xbus_master xbus_master_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
  .bus_req_n(bus_req_n), .bus_grant_n(bus_grant_n), .bus_ack_n(bus_ack_n),
  .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_cmd_oe(bus_cmd_oe),
  .bus_ad_oe(bus_ad_oe)
);

// File: tb/xbus_master_bench.sv
module xbus_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [BW-1:0] req_addr = '0, req_wdata = '0;
  logic req_write = 1'b0;
  logic [3:0] req_be = '0;
  logic [CW-1:0] cfg_a = '0, cfg_d = '0, cfg_g = '0;
  logic bus_grant_n = 1'b1;
  logic [BW-1:0] bus_ad_i = '0;
  logic req_ready, rsp_done, rsp_abort, bus_req_n, bus_ack_n, bus_as_n;
  logic bus_ds_n, bus_rw_n, bus_cmd_oe, bus_ad_oe;
  logic [3:0] bus_be_n;
  logic [BW-1:0] rsp_rdata, bus_ad_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_master #(.BUS_W(BW), .CNT_W(CW)) u_xbus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_be(req_be), .cfg_astretch(cfg_a), .cfg_dstretch(cfg_d),
    .cfg_gap(cfg_g), .rsp_done(rsp_done), .rsp_abort(rsp_abort),
    .rsp_rdata(rsp_rdata), .bus_req_n(bus_req_n), .bus_grant_n(bus_grant_n),
    .bus_ack_n(bus_ack_n), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
    .bus_rw_n(bus_rw_n), .bus_be_n(bus_be_n), .bus_cmd_oe(bus_cmd_oe),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
               tag, what, act, exp, cyc);
    end
  endtask

  // ---------------- arbiter model ----------------
  int  grant_delay = 0;
  bit  keep_grant = 0;
  bit  force_grant = 0;
  int  abort_after = 0;
  int  wait_cnt = 0, held = 0;
  bit  lock = 0;

  always @(negedge clk) begin
    cyc++;
    bus_ad_i <= {cyc[15:0], ~cyc[15:0]};
    if (!bus_req_n && !lock) begin
      if (wait_cnt >= grant_delay) bus_grant_n <= 1'b0;
      else wait_cnt++;
      if (!bus_grant_n) begin
        held++;
        if (abort_after != 0 && held == abort_after) begin
          bus_grant_n <= 1'b1;
          lock = 1;
        end
      end
    end else if (bus_req_n) begin
      wait_cnt = 0;
      held = 0;
      lock = 0;
      if (force_grant) bus_grant_n <= 1'b0;
      else if (!keep_grant) bus_grant_n <= 1'b1;
    end
  end

  // ---------------- reference model ----------------
  int  mode = 0;   // 0 idle, 1 parked, 2 requesting, 3 owning
  int  t = 0, gap = 0, ma = 0, md = 0, mg = 0;
  bit  mwr = 0;
  logic [BW-1:0] maddr, mwd, mcap;
  logic [3:0] mbe;
  bit  e_br = 1, e_ack = 1, e_as = 1, e_ds = 1, e_rw = 1, e_cmd = 0, e_adoe = 0;
  bit  e_done = 0, e_abort = 0, e_ready = 1;
  logic [3:0] e_be = '1;
  logic [BW-1:0] e_ad = '0, e_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      mode = 0; gap = 0; e_br = 1; e_ack = 1; e_as = 1; e_ds = 1; e_rw = 1;
      e_cmd = 0; e_adoe = 0; e_done = 0; e_abort = 0; e_be = '1; e_ready = 1;
    end else begin
      bit acc;
      acc = req_valid && e_ready;
      e_done = 0;
      if (gap > 0) gap--;
      if (mode <= 1) begin
        if (mode == 1 && bus_grant_n) e_cmd = 0;
        if (acc) begin
          maddr = req_addr; mwd = req_wdata; mwr = req_write; mbe = req_be;
          ma = int'(cfg_a); md = int'(cfg_d); mg = int'(cfg_g);
          e_br = 0; mode = 2;
        end else if (mode == 1 && bus_grant_n) mode = 0;
      end else if (mode == 2) begin
        if (bus_grant_n) e_cmd = 0;
        else begin
          mode = 3; t = 0; e_cmd = 1; e_as = 1; e_ds = 1;
          e_rw = !mwr; e_be = ~mbe;
        end
      end else begin
        t++;
        if (bus_grant_n && t <= 6 + ma + md) begin
          e_cmd = 0; e_adoe = 0; e_br = 1; e_ack = 1; e_as = 1; e_ds = 1;
          e_rw = 1; e_be = '1; e_done = 1; e_abort = 1; gap = mg; mode = 0;
        end else if (t == 1) begin e_adoe = 1; e_ad = maddr; end
        else if (t == 2) e_ack = 0;
        else if (t == 3 + ma) e_as = 0;
        else if (t == 4 + ma) begin
          if (mwr) e_ad = mwd; else e_adoe = 0;
        end
        else if (t == 5 + ma) e_ds = 0;
        else if (t == 6 + ma + md) begin e_ds = 1; e_ack = 1; mcap = bus_ad_i; end
        else if (t == 7 + ma + md) begin
          e_adoe = 0; e_as = 1; e_rw = 1; e_be = '1; e_br = 1; e_done = 1;
          e_abort = 0; e_rd = mcap; gap = mg;
          e_cmd = !bus_grant_n; mode = bus_grant_n ? 0 : 1;
        end
      end
      e_ready = (mode <= 1) && (gap == 0);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R2", "req_ready", req_ready, e_ready);
      check("R9", "bus_req_n", bus_req_n, e_br);
      check("R8", "bus_cmd_oe", bus_cmd_oe, e_cmd);
      check("R5", "bus_ad_oe", bus_ad_oe, e_adoe);
      if (e_cmd) begin
        check("R3", "bus_ack_n", bus_ack_n, e_ack);
        check("R4", "bus_as_n", bus_as_n, e_as);
        check("R6", "bus_ds_n", bus_ds_n, e_ds);
        check("R5", "bus_rw_n", bus_rw_n, e_rw);
        check("R3", "bus_be_n", bus_be_n, e_be);
      end
      if (e_adoe) check("R5", "bus_ad_o", bus_ad_o, e_ad);
      check("R7", "rsp_done", rsp_done, e_done);
      if (e_done) begin
        check("R10", "rsp_abort", rsp_abort, e_abort);
        if (!e_abort && !mwr) check("R6", "rsp_rdata", rsp_rdata, e_rd);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit wr, input logic [BW-1:0] a, input logic [BW-1:0] wd,
                      input logic [3:0] be, input int sa, input int sd, input int sg);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    cfg_a = CW'(sa); cfg_d = CW'(sd); cfg_g = CW'(sg);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!rsp_done) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "reset bus_req_n", bus_req_n, 1);
    check("R1", "reset cmd_oe", bus_cmd_oe, 0);
    check("R1", "reset ad_oe", bus_ad_oe, 0);

    // grant with nothing pending
    force_grant = 1; idle(5);
    check("R12", "stray grant cmd_oe", bus_cmd_oe, 0);
    check("R12", "stray grant ad_oe", bus_ad_oe, 0);
    force_grant = 0; idle(3);

    // plain write, no stretch, grant released after
    grant_delay = 1;
    send(1, 32'h1000_0010, 32'hCAFE_F00D, 4'b1111, 0, 0, 0);
    wait_done();
    check("R7", "write completes", rsp_abort, 0);
    idle(4);

    // read with stretches
    grant_delay = 3;
    send(0, 32'h2000_0020, 32'h0, 4'b0011, 2, 3, 1);
    wait_done(); idle(4);

    // parking: grant kept across back-to-back transfers with a gap
    keep_grant = 1; grant_delay = 0;
    send(1, 32'h3000_0030, 32'h1234_5678, 4'b0101, 1, 1, 2);
    send(0, 32'h3000_0034, 32'h0, 4'b1000, 0, 2, 0);
    wait_done(); idle(3);
    check("R8", "parked cmd_oe", bus_cmd_oe, 1);
    keep_grant = 0; idle(3);
    check("R8", "park exit cmd_oe", bus_cmd_oe, 0);

    // abort in address phase
    abort_after = 4; grant_delay = 1;
    send(1, 32'h4000_0040, 32'hDEAD_BEEF, 4'b1111, 3, 3, 1);
    wait_done();
    check("R10", "abort flag", rsp_abort, 1);
    idle(12);
    check("R10", "no reissue", bus_req_n, 1);

    // abort in data phase
    abort_after = 9;
    send(0, 32'h5000_0050, 32'h0, 4'b1111, 0, 5, 0);
    wait_done();
    check("R10", "late abort flag", rsp_abort, 1);
    abort_after = 0; idle(4);

    // stretch values change after acceptance
    grant_delay = 2;
    send(1, 32'h6000_0060, 32'h0BAD_CAFE, 4'b0110, 1, 0, 0);
    cfg_a = '1; cfg_d = '1; cfg_g = '1;
    begin
      int n = 0;
      while (bus_ack_n) @(negedge clk);
      while (bus_as_n) begin @(negedge clk); n++; end
      check("R11", "latched address stretch", n, 2);
    end
    wait_done(); idle(4);

    // maximum stretches
    send(0, 32'h7000_0070, 32'h0, 4'b1111, 15, 15, 15);
    wait_done();
    send(1, 32'h7000_0074, 32'h5555_AAAA, 4'b1001, 0, 0, 0);
    wait_done(); idle(6);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule